// File: doc/BRIEF.md
# Adaptive Dead-Time Threshold Regulator

This block holds the synchronous-rectifier dead time close to a target by moving a virtual turn-off threshold once per switching cycle. The dead time is the interval from the gate-off event (gate below its off level) to the drain-high event (drain sense above its high-detect level). Both events arrive as one-cycle digital pulses from comparators outside the block. A free-running counter with 10 ns resolution measures this interval.

The threshold is set by a single 32-position ladder. The lower half of the ladder selects the upper coarse turn-off level, which is used at heavy load. The upper half selects the lower coarse level, which is used at light load. Within each half, a 4-bit offset code picks one of sixteen offset-current steps. Pulsing the update strobe closes a cycle and applies the correction. A dead time that is too long moves the ladder down one position. A dead time that is too short moves it up one position, or two positions when the dead time is very short. A light-load flag comes from the ladder position, and this flag in turn raises the target.

Top module: `deadtime_ladder`

## Requirements
- R1: After reset, coarse_sel, offset_code and light_load are all 0 (ladder position 0).
- R2: The measured dead time D is the number of clock edges from the edge that samples gate_off to the edge that samples drain_high. If D is greater than the current target, an update lowers the ladder position by one.
- R3: If D is at least 5 but less than the target, an update raises the ladder position by one.
- R4: If D is less than 5 (below 50 ns), an update raises the ladder position by two.
- R5: If D equals the target, an update leaves the position unchanged.
- R6: The position saturates at 0 and at 31. A step that would pass either end stops at that end.
- R7: The outputs are {coarse_sel, offset_code} = position. coarse_sel = 1 selects the lower coarse level (positions 16..31), and offset_code is the position modulo 16.
- R8: At every update, light_load is set to (coarse_sel == 1 and offset_code > 8), evaluated on the new position.
- R9: The target is 28 ticks. It is 32 when light_load is set. With slow_sel = 1 these become 32 and 36. The target is taken from the light_load value held before the update.
- R10: An update makes no correction in three cases: no drain_high closed a measurement since the last gate_off, the count reached its full scale of 255, or the measurement was already consumed by an earlier update.
- R11: The outputs change only on the edge that samples upd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 ns per count tick |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_sel | input | 1 | 1 selects the slow target pair (32/36 instead of 28/32) |
| gate_off | input | 1 | One-cycle pulse: gate fell below its off level; starts the measurement |
| drain_high | input | 1 | One-cycle pulse: drain rose above the high-detect level; ends the measurement |
| upd | input | 1 | Cycle-end strobe: applies the correction |
| coarse_sel | output | 1 | 0 = upper coarse level (heavy load), 1 = lower coarse level |
| offset_code | output | 4 | Offset-current step, 0..15 |
| light_load | output | 1 | Light-load flag |

## Verification
The hardest case to reach is the narrow band of dead times around the target, where the outcome depends on the light-load flag left by the previous update. That band runs from 28 to 32 ticks, or from 32 to 36 with slow_sel set. The bench walks the ladder to both ends with runs of very short and very long dead times. Near the flag boundary at position 25, it then sweeps every dead time from 1 to 40 ticks, interleaved with long ones. A reference model in the bench tracks the flag, which places each exact-target case in both flag states and in both target sets. A run whose count reaches full scale, and a second update with no new measurement, cover the cases where no correction is made.

// File: rtl/dtl_pkg.sv
package dtl_pkg;

  // Ladder move: one step down, or one or two steps up, clamped to [0, top]
  function automatic int unsigned ladder_next(input int unsigned pos,
                                              input bit up, input bit dn,
                                              input bit dbl,
                                              input int unsigned top);
    int unsigned r;
    r = pos;
    if (dn) begin
      r = (pos == 0) ? 0 : pos - 1;
    end else if (up) begin
      r = pos + (dbl ? 2 : 1);
      if (r > top) r = top;
    end
    return r;
  endfunction

  // Light load: lower coarse half and offset above the limit
  function automatic bit ladder_light(input int unsigned pos,
                                      input int unsigned half,
                                      input int unsigned ofs_above);
    return (pos >= half) && ((pos - half) > ofs_above);
  endfunction

  // Dead-time target in ticks
  function automatic int target_ticks(input bit slow, input bit light,
                                      input int t_norm, input int t_light,
                                      input int t_slow, input int t_slow_light);
    if (slow) return light ? t_slow_light : t_slow;
    return light ? t_light : t_norm;
  endfunction

endpackage

// File: rtl/dtl_timer.sv
module dtl_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_off,
  input  logic             drain_high,
  input  logic             upd,
  output logic [CNT_W-1:0] cnt,
  output logic             meas_ok
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic running_q;
  logic done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      running_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (gate_off) begin
        cnt       <= '0;
        running_q <= 1'b1;
        done_q    <= 1'b0;
      end else begin
        if (running_q) begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          if (drain_high) begin
            running_q <= 1'b0;
            done_q    <= 1'b1;
          end
        end
        if (upd) done_q <= 1'b0;
      end
    end
  end

  // Measurement is usable only if closed and below full scale
  assign meas_ok = done_q && (cnt != CNT_MAX);

endmodule

// File: rtl/dtl_decide.sv
module dtl_decide #(
  parameter int CNT_W        = 8,
  parameter int T_NORM       = 28,
  parameter int T_LIGHT      = 32,
  parameter int T_SLOW       = 32,
  parameter int T_SLOW_LIGHT = 36,
  parameter int T_SHORT      = 5
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             meas_ok,
  input  logic             light,
  input  logic             slow_sel,
  output logic             step_up,
  output logic             step_dn,
  output logic             step_dbl
);
  int tgt;
  int dt;

  always_comb begin
    tgt      = dtl_pkg::target_ticks(slow_sel, light, T_NORM, T_LIGHT,
                                     T_SLOW, T_SLOW_LIGHT);
    dt       = int'(cnt);
    step_dn  = meas_ok && (dt > tgt);
    step_up  = meas_ok && (dt < tgt);
    step_dbl = step_up && (dt < T_SHORT);
  end

endmodule

// File: rtl/dtl_ladder.sv
module dtl_ladder #(
  parameter int OFS_W       = 4,
  parameter int LIGHT_ABOVE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             step_dbl,
  output logic [OFS_W:0]   pos,
  output logic             light
);
  localparam int POS_W = OFS_W + 1;
  localparam int TOP   = (1 << POS_W) - 1;
  localparam int HALF  = 1 << OFS_W;

  logic [POS_W-1:0] pos_nx;

  always_comb begin
    pos_nx = POS_W'(dtl_pkg::ladder_next(int'(pos), step_up, step_dn,
                                         step_dbl, TOP));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '0;
      light <= 1'b0;
    end else if (upd) begin
      pos   <= pos_nx;
      light <= dtl_pkg::ladder_light(int'(pos_nx), HALF, LIGHT_ABOVE);
    end
  end

endmodule

// File: rtl/deadtime_ladder.sv
module deadtime_ladder #(
  parameter int CNT_W        = 8,
  parameter int OFS_W        = 4,
  parameter int T_NORM       = 28,
  parameter int T_LIGHT      = 32,
  parameter int T_SLOW       = 32,
  parameter int T_SLOW_LIGHT = 36,
  parameter int T_SHORT      = 5,
  parameter int LIGHT_ABOVE  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_sel,
  input  logic             gate_off,
  input  logic             drain_high,
  input  logic             upd,
  output logic             coarse_sel,
  output logic [OFS_W-1:0] offset_code,
  output logic             light_load
);
  localparam int POS_W = OFS_W + 1;

  logic [CNT_W-1:0] dt_cnt;
  logic             meas_ok;
  logic             step_up;
  logic             step_dn;
  logic             step_dbl;
  logic [POS_W-1:0] pos;

  dtl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_off   (gate_off),
    .drain_high (drain_high),
    .upd        (upd),
    .cnt        (dt_cnt),
    .meas_ok    (meas_ok)
  );

  dtl_decide #(
    .CNT_W(CNT_W), .T_NORM(T_NORM), .T_LIGHT(T_LIGHT), .T_SLOW(T_SLOW),
    .T_SLOW_LIGHT(T_SLOW_LIGHT), .T_SHORT(T_SHORT)
  ) u_decide (
    .cnt      (dt_cnt),
    .meas_ok  (meas_ok),
    .light    (light_load),
    .slow_sel (slow_sel),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .step_dbl (step_dbl)
  );

  dtl_ladder #(.OFS_W(OFS_W), .LIGHT_ABOVE(LIGHT_ABOVE)) u_ladder (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (upd),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .step_dbl (step_dbl),
    .pos      (pos),
    .light    (light_load)
  );

  assign coarse_sel  = pos[POS_W-1];
  assign offset_code = pos[OFS_W-1:0];

endmodule

// File: rtl/deadtime_ladder_chk.sv
module deadtime_ladder_chk #(
  parameter int OFS_W       = 4,
  parameter int LIGHT_ABOVE = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd,
  input logic             coarse_sel,
  input logic [OFS_W-1:0] offset_code,
  input logic             light_load,
  input logic             meas_ok,
  input logic             step_up,
  input logic             step_dn,
  input logic             step_dbl
);
  localparam int POS_W = OFS_W + 1;
  localparam logic [POS_W-1:0] TOP = '1;

  logic [POS_W-1:0] pos_w;
  assign pos_w = {coarse_sel, offset_code};

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(pos_w) && $stable(light_load))); // R11

  AST_FLAG_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (light_load == (coarse_sel && (int'(offset_code) > LIGHT_ABOVE)))); // R8

  AST_NO_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !meas_ok) |=> $stable(pos_w)); // R10

  AST_STEP_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && step_dn && pos_w != '0) |=> (pos_w == $past(pos_w) - 1'b1)); // R2

  AST_STEP_UP1: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && step_up && !step_dbl && pos_w != TOP) |=> (pos_w == $past(pos_w) + 1'b1)); // R3

  AST_STEP_UP2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && step_dbl && pos_w < TOP - 1'b1) |=> (pos_w == $past(pos_w) + 2'd2)); // R4

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && step_up && pos_w == TOP) |=> (pos_w == TOP)); // R6

  AST_SAT_BOT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && step_dn && pos_w == '0) |=> (pos_w == '0)); // R6

  AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn})); // R5

  AST_DBL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    step_dbl |-> step_up); // R4

endmodule

bind deadtime_ladder deadtime_ladder_chk #(.OFS_W(OFS_W), .LIGHT_ABOVE(LIGHT_ABOVE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .upd         (upd),
  .coarse_sel  (coarse_sel),
  .offset_code (offset_code),
  .light_load  (light_load),
  .meas_ok     (meas_ok),
  .step_up     (step_up),
  .step_dn     (step_dn),
  .step_dbl    (step_dbl)
);

// File: tb/deadtime_ladder_tb.sv
module deadtime_ladder_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_sel = 1'b0;
  logic       gate_off = 1'b0;
  logic       drain_high = 1'b0;
  logic       upd = 1'b0;
  logic       coarse_sel;
  logic [3:0] offset_code;
  logic       light_load;

  int total = 0;
  int bad = 0;
  int ep = 0;     // expected ladder position
  bit ef = 1'b0;  // expected light-load flag

  always #(CLK_PERIOD/2) clk = ~clk;

  deadtime_ladder u_dut (
    .clk(clk), .rst_n(rst_n), .slow_sel(slow_sel), .gate_off(gate_off),
    .drain_high(drain_high), .upd(upd), .coarse_sel(coarse_sel),
    .offset_code(offset_code), .light_load(light_load)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, {27'd0, coarse_sel, offset_code}, ep);
    chk("R8 light flag", int'(light_load), int'(ef));
    chk("R7 coarse select", int'(coarse_sel), int'(ep >= 16));
    chk("R7 offset code", int'(offset_code), ep % 16);
  endtask

  function automatic int tgt(input bit s, input bit lf);
    if (s) return lf ? 36 : 32;
    return lf ? 32 : 28;
  endfunction

  // 0: hold, 1: down, 2: up one, 3: up two
  function automatic int kind(input int d, input int t);
    if (d > t) return 1;
    if (d < 5) return 3;
    if (d < t) return 2;
    return 0;
  endfunction

  task automatic pulse_upd();
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ep = 0;
    ef = 1'b0;
    chk_all("R1 reset position");
  endtask

  task automatic op(input int d);
    int t;
    int k;
    int raw;
    string tag;
    t = tgt(slow_sel, ef);
    k = kind(d, t);
    @(negedge clk);
    gate_off = 1'b1;
    @(negedge clk);
    gate_off = 1'b0;
    repeat (d - 1) @(negedge clk);
    drain_high = 1'b1;
    @(negedge clk);
    drain_high = 1'b0;
    chk("R11 hold before update", {27'd0, coarse_sel, offset_code}, ep);
    pulse_upd();
    case (k)
      1: begin tag = "R2 long dead time";     raw = ep - 1; end
      2: begin tag = "R3 short dead time";    raw = ep + 1; end
      3: begin tag = "R4 very short doubled"; raw = ep + 2; end
      default: begin tag = "R5 on target";    raw = ep;     end
    endcase
    if (k != kind(d, tgt(slow_sel, !ef))) tag = {tag, " R9 target select"};
    if (raw < 0 || raw > 31) tag = {tag, " R6 saturation"};
    ep = (raw < 0) ? 0 : ((raw > 31) ? 31 : raw);
    ef = (ep >= 25);
    chk_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      slow_sel = s[0];
      do_reset();
      // R10: update with no measurement
      @(negedge clk);
      pulse_upd();
      chk_all("R10 update without measurement");
      // R6 bottom saturation
      for (int i = 0; i < 3; i++) op(60);
      // climb to top with doubled steps, R4 and R6
      for (int i = 0; i < 18; i++) op(1);
      // exact target with flag set
      op(tgt(slow_sel, 1'b1));
      op(28);
      // sweep all dead times, interleaving down steps
      for (int d = 1; d <= 40; d++) begin
        op(d);
        op(60);
      end
      // walk down across the flag boundary
      for (int i = 0; i < 22; i++) op(45);
      // exact target with flag clear
      op(tgt(slow_sel, 1'b0));
      op(32);
      for (int d = 40; d >= 1; d--) op(d);
      // R10: count reaches full scale before drain_high
      @(negedge clk);
      gate_off = 1'b1;
      @(negedge clk);
      gate_off = 1'b0;
      repeat (300) @(negedge clk);
      drain_high = 1'b1;
      @(negedge clk);
      drain_high = 1'b0;
      pulse_upd();
      ef = (ep >= 25);
      chk_all("R10 saturated count");
      // R10: measurement already consumed
      op(60);
      pulse_upd();
      chk_all("R10 repeated update");
      // R10: gate_off without drain_high
      @(negedge clk);
      gate_off = 1'b1;
      @(negedge clk);
      gate_off = 1'b0;
      repeat (10) @(negedge clk);
      pulse_upd();
      chk_all("R10 open measurement");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule